// File: doc/BRIEF.md
# Destination address hash filter

This block decides whether an incoming Ethernet frame is addressed to this station. It takes the six destination address bytes one per cycle, in the order they arrive on the wire. From them it forms a 48-bit address and folds that address into a 6-bit index. The index selects one bit of a 64-bit table that software loads as two 32-bit halves. The block then reports whether the frame is accepted and gives a code for the reason.

Besides the hashed group and individual matches, the block compares the address exactly against a programmed station address. It can also refuse the all-ones broadcast address, or accept every frame in a promiscuous mode. The mode bits are inputs that the surrounding MAC holds steady, and they are sampled in the cycle that carries the last address byte. Software loads the table and the station address through a small write port that selects one of four 32-bit words.

Top module: `dest_addr_filter`

## Requirements
- R1: After a synchronous active-high reset, `result_valid`, `accept` and `reason` are 0. The hash table and the station address are cleared.
- R2: Address byte k (k = 0..5, counted from the first received) fills address bits 8k+7..8k. Address bit 0 is the LSB of byte 0. It marks a group address when it is 1 and an individual address when it is 0.
- R3: Hash index bit n (n = 0..5) is the XOR of address bits n, n+6, n+12, n+18, n+24, n+30, n+36 and n+42.
- R4: With `mc_hash_en` = 1, a group address whose indexed table bit is 1 is accepted with reason 3. Filling the table with ones accepts every non-broadcast group address.
- R5: With `uc_hash_en` = 1, an individual address whose indexed table bit is 1 is accepted with reason 4. A hash hit on an address whose own enable is 0 does not cause acceptance.
- R6: A write with `wr_sel` = 0 loads table bits 31..0 and a write with `wr_sel` = 1 loads table bits 63..32. Index i looks up table bit i.
- R7: `wr_sel` = 2 loads the station address bytes 0..3, with byte 0 in `wr_data[7:0]`. `wr_sel` = 3 loads bytes 4 and 5 from `wr_data[15:0]`, and `wr_data[31:16]` is ignored. An exact match gives reason 1, and this match has top priority.
- R8: The all-ones address is accepted with reason 2 while `no_bcast` = 0. It never takes a hash reason, even when its indexed table bit is 1.
- R9: While `no_bcast` = 1 the all-ones address is rejected, unless it matches the station address or `copy_all` = 1.
- R10: With `copy_all` = 1, every frame is accepted. The reason is 5 only when no station, broadcast or hash reason applies. Reason 0 means rejected.
- R11: `result_valid` pulses for exactly one cycle, one clock after the sixth byte is taken. `accept` is 1 exactly when `reason` is non-zero. Both hold their value until the next result.
- R12: `byte_valid` together with `frame_start` marks byte 0. Bytes after the sixth are ignored until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Word select: 0 table low, 1 table high, 2 station bytes 0..3, 3 station bytes 4..5 |
| wr_data | input | 32 | Configuration write data |
| mc_hash_en | input | 1 | Enable hashed group matching |
| uc_hash_en | input | 1 | Enable hashed individual matching |
| copy_all | input | 1 | Accept every frame |
| no_bcast | input | 1 | Reject the all-ones address |
| frame_start | input | 1 | Restarts byte counting; the byte on this cycle is byte 0 |
| byte_valid | input | 1 | An address byte is present |
| byte_data | input | 8 | Address byte |
| result_valid | output | 1 | One-cycle pulse when a decision is ready |
| accept | output | 1 | Frame accepted |
| reason | output | 3 | 0 reject, 1 station, 2 broadcast, 3 group hash, 4 individual hash, 5 copy-all |

## Verification
The hardest cases to reach from the ports are the ones where several reasons apply to the same address at once. One example is an all-ones address whose hash bit is set while broadcasts are refused. Another is an individual address whose table bit is set while only group matching is enabled. Random addresses almost never land on these. The stimulus therefore mixes random frames with frames that reuse the programmed station address or the all-ones address. Directed cases compute the target index in the bench, then program a table with only that bit set, in either half, before sending the frame.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int HASH_BITS  = 6;
    localparam int TABLE_W    = 1 << HASH_BITS;
    localparam int REG_W      = 32;
    localparam int HALVES     = TABLE_W / REG_W;
    localparam int FOLDS      = ADDR_W / HASH_BITS;
    localparam int TOP_W      = ADDR_W - REG_W;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_STATION  = 3'd1,
        RSN_BCAST    = 3'd2,
        RSN_MC_HASH  = 3'd3,
        RSN_UC_HASH  = 3'd4,
        RSN_COPY_ALL = 3'd5
    } reason_e;

    typedef enum logic [1:0] {
        SEL_HASH_LO = 2'd0,
        SEL_HASH_HI = 2'd1,
        SEL_STA_BOT = 2'd2,
        SEL_STA_TOP = 2'd3
    } wsel_e;

    typedef struct packed {
        logic mc_en;
        logic uc_en;
        logic copy_all;
        logic no_bcast;
    } mode_t;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    function automatic logic is_all_ones(input logic [ADDR_W-1:0] a);
        return &a;
    endfunction
endpackage

// File: rtl/daf_collect.sv
module daf_collect
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              addr_done,
    output logic [ADDR_W-1:0] addr
);
    localparam int CW = $clog2(ADDR_BYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);
    localparam logic [CW-1:0] FULL = CW'(ADDR_BYTES);

    logic [CW-1:0] cnt;
    logic [CW-1:0] eff_cnt;
    logic          take;
    logic [ADDR_W-BYTE_W-1:0] held;

    assign eff_cnt   = frame_start ? '0 : cnt;
    assign take      = byte_valid && (eff_cnt < FULL);
    assign addr_done = take && (eff_cnt == LAST);
    assign addr      = {byte_data, held};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= eff_cnt + CW'(1);
        end else if (frame_start) begin
            cnt <= '0;
        end
    end

    for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                held[k*BYTE_W +: BYTE_W] <= '0;
            end else if (take && (eff_cnt == CW'(k))) begin
                held[k*BYTE_W +: BYTE_W] <= byte_data;
            end
        end
    end
endmodule

// File: rtl/daf_hash.sv
module daf_hash
    import daf_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    output logic [HASH_BITS-1:0] idx
);
    for (genvar n = 0; n < HASH_BITS; n++) begin : g_bit
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int i = 0; i < FOLDS; i++) begin
                acc = acc ^ addr[i*HASH_BITS + n];
            end
        end
        assign idx[n] = acc;
    end
endmodule

// File: rtl/daf_regs.sv
module daf_regs
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [TABLE_W-1:0] table_q,
    output logic [ADDR_W-1:0]  station_q
);
    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[h*REG_W +: REG_W] <= '0;
            end else if (wr_en && (wr_sel == 2'(h))) begin
                table_q[h*REG_W +: REG_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            station_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_STA_BOT) begin
                station_q[REG_W-1:0] <= wr_data;
            end else if (sel == SEL_STA_TOP) begin
                station_q[ADDR_W-1:REG_W] <= wr_data[TOP_W-1:0];
            end
        end
    end
endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic [HASH_BITS-1:0] idx,
    input  logic [TABLE_W-1:0]   table_q,
    input  logic [ADDR_W-1:0]    station_q,
    input  mode_t                mode,
    output verdict_t             verdict
);
    logic hit_bit;
    logic sta_hit;
    logic bcast;
    logic group;

    assign hit_bit = table_q[idx];
    assign sta_hit = (addr == station_q);
    assign bcast   = is_all_ones(addr);
    assign group   = addr[0];

    always_comb begin
        verdict.reason = RSN_NONE;
        if (sta_hit) begin
            verdict.reason = RSN_STATION;
        end else if (bcast) begin
            if (!mode.no_bcast) begin
                verdict.reason = RSN_BCAST;
            end else if (mode.copy_all) begin
                verdict.reason = RSN_COPY_ALL;
            end
        end else if (group && mode.mc_en && hit_bit) begin
            verdict.reason = RSN_MC_HASH;
        end else if (!group && mode.uc_en && hit_bit) begin
            verdict.reason = RSN_UC_HASH;
        end else if (mode.copy_all) begin
            verdict.reason = RSN_COPY_ALL;
        end
        verdict.accept = (verdict.reason != RSN_NONE);
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        mc_hash_en,
    input  logic        uc_hash_en,
    input  logic        copy_all,
    input  logic        no_bcast,
    input  logic        frame_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        result_valid,
    output logic        accept,
    output logic [2:0]  reason
);
    logic [ADDR_W-1:0]    addr;
    logic                 addr_done;
    logic [HASH_BITS-1:0] idx;
    logic [TABLE_W-1:0]   table_q;
    logic [ADDR_W-1:0]    station_q;
    mode_t                mode;
    verdict_t             verdict;
    verdict_t             verdict_q;

    assign mode = '{mc_en: mc_hash_en, uc_en: uc_hash_en,
                    copy_all: copy_all, no_bcast: no_bcast};

    daf_collect u_collect (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .addr_done   (addr_done),
        .addr        (addr)
    );

    daf_hash u_hash (
        .addr (addr),
        .idx  (idx)
    );

    daf_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .table_q   (table_q),
        .station_q (station_q)
    );

    daf_decide u_decide (
        .addr      (addr),
        .idx       (idx),
        .table_q   (table_q),
        .station_q (station_q),
        .mode      (mode),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            verdict_q    <= '{accept: 1'b0, reason: RSN_NONE};
        end else begin
            result_valid <= addr_done;
            if (addr_done) begin
                verdict_q <= verdict;
            end
        end
    end

    assign accept = verdict_q.accept;
    assign reason = verdict_q.reason;
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
    input logic        clk,
    input logic        rst,
    input logic        mc_hash_en,
    input logic        uc_hash_en,
    input logic        no_bcast,
    input logic        byte_valid,
    input logic        result_valid,
    input logic        accept,
    input logic [2:0]  reason
);
    // R1: reset leaves no result pending
    assert_rst_quiet_R1: assert property (@(posedge clk)
        rst |=> (!result_valid && !accept && reason == 3'd0));

    // R11: a result always follows a byte that was taken
    assert_valid_after_byte_R11: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(byte_valid));

    // R11: single-cycle pulse
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R11: verdict held between results
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> ($stable(reason) && $stable(accept)));

    // R11: accept agrees with reason code
    assert_accept_code_R11: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (accept == (reason != 3'd0)));

    // R4: group hash reason needs its enable
    assert_mc_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (result_valid && reason == 3'd3) |-> $past(mc_hash_en));

    // R5: individual hash reason needs its enable
    assert_uc_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (result_valid && reason == 3'd4) |-> $past(uc_hash_en));

    // R9: broadcast reason never while broadcasts are refused
    assert_bcast_block_R9: assert property (@(posedge clk) disable iff (rst)
        (result_valid && reason == 3'd2) |-> !$past(no_bcast));
endmodule

bind dest_addr_filter daf_checker u_chk (.*);

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        mc_hash_en, uc_hash_en, copy_all, no_bcast;
    logic        frame_start, byte_valid;
    logic [7:0]  byte_data;
    logic        result_valid, accept;
    logic [2:0]  reason;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_table;
    logic [47:0] m_sta;

    always #4 clk = ~clk;

    dest_addr_filter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mc_hash_en(mc_hash_en), .uc_hash_en(uc_hash_en), .copy_all(copy_all),
        .no_bcast(no_bcast), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .result_valid(result_valid), .accept(accept),
        .reason(reason)
    );

    function automatic logic [5:0] b_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int n = 0; n < 6; n++)
            for (int i = 0; i < 8; i++)
                h[n] = h[n] ^ a[6*i + n];
        return h;
    endfunction

    function automatic logic [2:0] b_reason(input logic [47:0] a);
        logic hb = m_table[b_hash(a)];
        if (a == m_sta) return 3'd1;
        if (a == {48{1'b1}}) begin
            if (!no_bcast) return 3'd2;
            if (copy_all) return 3'd5;
            return 3'd0;
        end
        if (a[0] && mc_hash_en && hb) return 3'd3;
        if (!a[0] && uc_hash_en && hb) return 3'd4;
        if (copy_all) return 3'd5;
        return 3'd0;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_table[31:0]  = d;
            2'd1: m_table[63:32] = d;
            2'd2: m_sta[31:0]    = d;
            default: m_sta[47:32] = d[15:0];
        endcase
    endtask

    task automatic set_mode(input logic mc, input logic uc, input logic ca, input logic nb);
        mc_hash_en = mc; uc_hash_en = uc; copy_all = ca; no_bcast = nb;
    endtask

    // drive six bytes; returns at the negedge after the result edge
    task automatic send(input logic [47:0] a);
        for (int k = 0; k < 6; k++) begin
            byte_valid = 1'b1; frame_start = (k == 0); byte_data = a[8*k +: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0; frame_start = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input string tag);
        logic [2:0] e = b_reason(a);
        send(a);
        check(result_valid === 1'b1, {tag, " valid"}, result_valid, 1);
        check(reason === e, {tag, " reason"}, reason, e);
        check(accept === (e != 3'd0), {tag, " accept"}, accept, e != 3'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0;
        set_mode(0, 0, 0, 0);
        frame_start = 0; byte_valid = 0; byte_data = 0;
        m_table = '0; m_sta = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check(result_valid === 0 && accept === 0 && reason === 0, "R1 reset outputs",
              {result_valid, accept, reason}, 0);
        frame(48'h0000_1234_5601, "R1 cleared table rejects");

        // R4: all-ones table accepts group addresses
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFF);
        set_mode(1, 0, 0, 0);
        frame(48'h1357_9BDF_0A01, "R4 all-ones group");
        check(reason === 3'd3, "R4 code", reason, 3);
        // R5: individual address with only group enable is rejected
        frame(48'h1357_9BDF_0A02, "R5 enable off");
        check(accept === 0, "R5 rejected", accept, 0);
        set_mode(0, 1, 0, 0);
        frame(48'h1357_9BDF_0A02, "R5 individual hit");
        check(reason === 3'd4, "R5 code", reason, 4);

        // R3/R6/R2: single-bit table in each half
        a = 48'h00A5_3C96_E701; ix = b_hash(a);
        set_mode(1, 1, 0, 0);
        wr(2'd0, 32'h0); wr(2'd1, 32'h0);
        if (ix < 32) wr(2'd0, 32'h1 << ix); else wr(2'd1, 32'h1 << (ix - 32));
        frame(a, "R3 R6 indexed bit");
        check(accept === 1, "R6 single bit hit", accept, 1);
        frame(a ^ 48'h1000_0000_0000, "R3 neighbour index miss");
        check(accept === 0, "R3 neighbour rejected", accept, 0);
        a = 48'h0F0F_0F0F_0F02; ix = b_hash(a);
        wr(2'd0, 32'h0); wr(2'd1, 32'h0);
        if (ix < 32) wr(2'd0, 32'h1 << ix); else wr(2'd1, 32'h1 << (ix - 32));
        frame(a, "R2 R6 individual indexed");
        check(reason === 3'd4, "R2 bit0 individual", reason, 4);

        // R8/R9: broadcast with hash bit set
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFF);
        frame({48{1'b1}}, "R8 broadcast");
        check(reason === 3'd2, "R8 not hash", reason, 2);
        set_mode(1, 1, 0, 1);
        frame({48{1'b1}}, "R9 refused");
        check(accept === 0, "R9 rejected", accept, 0);
        set_mode(1, 1, 1, 1);
        frame({48{1'b1}}, "R10 copy-all overrides refusal");

        // R7: station match with junk in upper write bits
        set_mode(0, 0, 0, 1);
        wr(2'd2, 32'h4433_2211); wr(2'd3, 32'hDEAD_6655);
        frame(48'h6655_4433_2211, "R7 station");
        check(reason === 3'd1, "R7 code", reason, 1);

        // R10: copy-all
        set_mode(0, 0, 1, 0); wr(2'd0, 0); wr(2'd1, 0);
        frame(48'h7777_8888_9902, "R10 copy-all");
        check(reason === 3'd5, "R10 code", reason, 5);

        // R11/R12: pulse, hold, extra bytes ignored
        set_mode(0, 0, 0, 0);
        frame(48'h0000_0000_0502, "R11 reject");
        check(result_valid === 0, "R11 single pulse", result_valid, 0);
        set_mode(0, 0, 1, 0);
        for (int k = 0; k < 8; k++) begin
            byte_valid = 1'b1; frame_start = 1'b0; byte_data = 8'(k);
            @(negedge clk);
            check(result_valid === 0, "R12 extra byte ignored", result_valid, 0);
        end
        byte_valid = 1'b0;
        check(reason === 3'd0 && accept === 0, "R11 R12 verdict held", reason, 0);

        // random mix
        for (int f = 0; f < 400; f++) begin
            int r;
            if (f % 16 == 0) begin
                wr(2'd0, $urandom); wr(2'd1, $urandom);
                wr(2'd2, $urandom); wr(2'd3, $urandom);
                set_mode(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
            end
            r = $urandom % 8;
            if (r == 0) a = m_sta;
            else if (r == 1) a = {48{1'b1}};
            else a = {16'($urandom), $urandom};
            frame(a, "R2 R3 R4 R5 R7 R8 R9 R10 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule